// File: doc/BRIEF.md
# Byte-Serial Program Memory Programming Port

This block is the device-side controller used while an external programmer writes, reads back and verifies a 16-bit-wide program memory over an 8-bit bidirectional data bus. No address is ever presented to the device. An internal byte pointer is cleared by a dedicated mode and stepped by pulses on a separate address-advance clock pin. Each 16-bit word occupies two byte positions: the upper byte sits at the even byte address and the lower byte at the odd one that follows.

A 4-bit mode input selects the operation, and nothing happens unless the programming-voltage flag is high. In write mode the byte on the data bus is captured while mode bit 0 is low. The byte is committed to the memory, as a single byte-lane write strobe, at the moment bit 0 rises. In read/verify mode the byte at the pointer is driven with an output enable while bit 0 is low. The memory itself sits outside the block as a synchronous RAM with one cycle of read latency and per-byte write enables. All pin inputs pass through a two-stage synchronizer into the system clock domain.

Top module: `prom_byteser_prog`

## Requirements
- R1: The mode input is read with bit 0 as the least significant bit. Code 4'b0101 clears the pointer, 4'b1110 selects write, 4'b1100 selects read/verify, and 4'b1101 or 4'b1111 selects inhibit. Any other code neither writes, drives the bus nor clears.
- R2: While `vpp_ok` is low, the block ignores every mode and every pulse on `prog_clk`. The pointer stays unchanged, no write strobe is issued and `d_oe` stays low.
- R3: The clear mode sets the byte pointer to 0 and resets the four-pulse phase counter, so that a complete fresh group of four pulses is needed before the next step.
- R4: Outside clear mode, the pointer steps by one for each group of four falling edges on `prog_clk`. The step happens on the third falling edge of each group.
- R5: A read at an even byte address returns bits 15:8 of the addressed word. A read at an odd byte address returns bits 7:0 of the same word (word index = byte address / 2).
- R6: In write mode, the value of `d_in` seen last while bit 0 is low is written when bit 0 rises (write becomes inhibit). The write is exactly one `mem_wr` strobe, with `mem_be` = 2'b10 for an even pointer and 2'b01 for an odd one. The other byte of the word is left unchanged.
- R7: `d_oe` is high only in read/verify mode while bit 0 is low. `mem_wr` and `d_oe` are never high together, and both are low after reset.
- R8: Repeated write strobes at one pointer position are allowed. The last one wins, and the pointer does not move.
- R9: The pointer saturates at the last byte address, 2*WORDS-1 (24319 by default), and does not wrap.
- R10: If a write commit and a pointer step land in the same cycle, the write uses the pointer value from before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_clk | input | 1 | Address-advance clock pin |
| mode | input | 4 | Mode select pins, bit 0 first |
| vpp_ok | input | 1 | Programming voltage present |
| d_in | input | 8 | Data bus, input side |
| d_out | output | 8 | Data bus, output side |
| d_oe | output | 1 | Data bus output enable |
| mem_addr | output | WAW | Word address to the memory |
| mem_wr | output | 1 | One-cycle write strobe |
| mem_be | output | 2 | Byte lane enables, bit 1 = upper byte |
| mem_wdata | output | 16 | Write data, byte replicated on both lanes |
| mem_rdata | input | 16 | Read data, one cycle after `mem_addr` |

## Verification
Two functions can fall in the same cycle: the pointer step on the third falling edge of `prog_clk`, and the write commit on the rise of mode bit 0. The bench provokes the collision by placing the pointer at phase two in write mode, then lowering `prog_clk` and raising bit 0 on the same clock edge. It then judges the result by reading back through the bus. The byte must have landed at the old address, the pointer must have moved on, and exactly one strobe must have been seen. Clear mode arriving part-way through a pulse group is treated the same way: the bench checks that a single further pulse does not step the pointer.

// File: rtl/prom_prog_pkg.sv
package prom_prog_pkg;

  typedef enum logic [2:0] {
    PM_NONE,
    PM_CLEAR,
    PM_WRITE,
    PM_READ,
    PM_INHIBIT
  } pmode_e;

  // bit 0 of md is the first mode pin
  function automatic pmode_e decode_mode(input logic [3:0] md);
    pmode_e m;
    m = PM_NONE;
    if (md == 4'b0101)                           m = PM_CLEAR;
    else if (md == 4'b1110)                      m = PM_WRITE;
    else if (md == 4'b1100)                      m = PM_READ;
    else if (md[0] && md[2] && md[3])            m = PM_INHIBIT;
    return m;
  endfunction

endpackage

// File: rtl/prom_pin_sync.sv
module prom_pin_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_sync
);

  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign pin_sync = chain[STAGES-1];

endmodule

// File: rtl/prom_addr_seq.sv
module prom_addr_seq #(
  parameter int WORDS = 12160,
  localparam int ABW  = $clog2(2 * WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           clear,
  input  logic           pclk_fall,
  output logic [ABW-1:0] byte_addr
);

  localparam logic [ABW-1:0] LAST_BYTE = ABW'(2 * WORDS - 1);
  localparam logic [1:0]     STEP_PH   = 2'd2;

  logic [1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      byte_addr <= '0;
    end else if (active && clear) begin
      phase     <= '0;
      byte_addr <= '0;
    end else if (active && pclk_fall) begin
      phase <= phase + 2'd1;
      if (phase == STEP_PH && byte_addr != LAST_BYTE)
        byte_addr <= byte_addr + 1'b1;
    end
  end

endmodule

// File: rtl/prom_byte_port.sv
module prom_byte_port
  import prom_prog_pkg::*;
#(
  parameter int WORDS = 12160,
  localparam int ABW  = $clog2(2 * WORDS),
  localparam int WAW  = ABW - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  pmode_e         cur_mode,
  input  pmode_e         prev_mode,
  input  logic [ABW-1:0] byte_addr,
  input  logic [7:0]     d_in,
  input  logic [15:0]    mem_rdata,
  output logic [7:0]     d_out,
  output logic           d_oe,
  output logic [WAW-1:0] mem_addr,
  output logic           mem_wr,
  output logic [1:0]     mem_be,
  output logic [15:0]    mem_wdata
);

  logic [7:0] wr_latch;
  logic       lo_byte;

  assign lo_byte  = byte_addr[0];
  assign mem_addr = byte_addr[ABW-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              wr_latch <= '0;
    else if (active && cur_mode == PM_WRITE) wr_latch <= d_in;
  end

  // commit on the write -> inhibit transition (bit 0 rising)
  assign mem_wr    = active && prev_mode == PM_WRITE && cur_mode == PM_INHIBIT;
  assign mem_be    = lo_byte ? 2'b01 : 2'b10;
  assign mem_wdata = {wr_latch, wr_latch};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_oe  <= 1'b0;
      d_out <= '0;
    end else begin
      d_oe  <= active && cur_mode == PM_READ;
      d_out <= lo_byte ? mem_rdata[7:0] : mem_rdata[15:8];
    end
  end

endmodule

// File: rtl/prom_byteser_prog.sv
module prom_byteser_prog
  import prom_prog_pkg::*;
#(
  parameter int WORDS       = 12160,
  parameter int SYNC_STAGES = 2,
  localparam int ABW        = $clog2(2 * WORDS),
  localparam int WAW        = ABW - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prog_clk,
  input  logic [3:0]     mode,
  input  logic           vpp_ok,
  input  logic [7:0]     d_in,
  output logic [7:0]     d_out,
  output logic           d_oe,
  output logic [WAW-1:0] mem_addr,
  output logic           mem_wr,
  output logic [1:0]     mem_be,
  output logic [15:0]    mem_wdata,
  input  logic [15:0]    mem_rdata
);

  logic [5:0]     pins_s;
  logic           pclk_s, pclk_q, vpp_s;
  logic [3:0]     mode_s;
  pmode_e         cur_mode, prev_mode;
  logic           active, pclk_fall, clr_now;
  logic [ABW-1:0] byte_addr;

  prom_pin_sync #(.W(6), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   ({vpp_ok, prog_clk, mode}),
    .pin_sync (pins_s)
  );

  assign mode_s   = pins_s[3:0];
  assign pclk_s   = pins_s[4];
  assign vpp_s    = pins_s[5];
  assign cur_mode = decode_mode(mode_s);
  assign active   = vpp_s;
  assign clr_now  = cur_mode == PM_CLEAR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q    <= 1'b0;
      prev_mode <= PM_NONE;
    end else begin
      pclk_q    <= pclk_s;
      prev_mode <= cur_mode;
    end
  end

  assign pclk_fall = pclk_q && !pclk_s;

  prom_addr_seq #(.WORDS(WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .clear     (clr_now),
    .pclk_fall (pclk_fall),
    .byte_addr (byte_addr)
  );

  prom_byte_port #(.WORDS(WORDS)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .cur_mode  (cur_mode),
    .prev_mode (prev_mode),
    .byte_addr (byte_addr),
    .d_in      (d_in),
    .mem_rdata (mem_rdata),
    .d_out     (d_out),
    .d_oe      (d_oe),
    .mem_addr  (mem_addr),
    .mem_wr    (mem_wr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata)
  );

endmodule

// File: rtl/prom_byteser_prog_chk.sv
module prom_byteser_prog_chk #(
  parameter int WORDS = 12160,
  localparam int ABW  = $clog2(2 * WORDS)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           active,
  input logic           clr_now,
  input logic [ABW-1:0] byte_addr,
  input logic           mem_wr,
  input logic [1:0]     mem_be,
  input logic           d_oe
);

  localparam logic [ABW-1:0] LAST_BYTE = ABW'(2 * WORDS - 1);

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (active && clr_now) |=> (byte_addr == '0));

  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_addr != $past(byte_addr)) |->
      (byte_addr == '0 || byte_addr == $past(byte_addr) + 1'b1));

  a_r9_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    byte_addr <= LAST_BYTE);

  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(d_oe && mem_wr));

  a_r6_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($countones(mem_be) == 1));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(byte_addr));

endmodule

bind prom_byteser_prog prom_byteser_prog_chk #(.WORDS(WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .active    (active),
  .clr_now   (clr_now),
  .byte_addr (byte_addr),
  .mem_wr    (mem_wr),
  .mem_be    (mem_be),
  .d_oe      (d_oe)
);

// File: tb/prom_byteser_prog_bench.sv
module prom_byteser_prog_bench;

  localparam int CLK_P  = 10;
  localparam int NW     = 40;
  localparam int ABW    = $clog2(2 * NW);
  localparam int WAW    = ABW - 1;
  localparam int LASTB  = 2 * NW - 1;
  localparam logic [3:0] MD_CLR = 4'b0101;
  localparam logic [3:0] MD_WR  = 4'b1110;
  localparam logic [3:0] MD_RD  = 4'b1100;
  localparam logic [3:0] MD_INH = 4'b1101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_clk = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic vpp_ok = 1'b0;
  logic [7:0] d_in = '0;
  logic [7:0] d_out;
  logic d_oe;
  logic [WAW-1:0] mem_addr;
  logic mem_wr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  int total = 0;
  int bad = 0;
  int wr_seen = 0;
  int exp_addr = 0;
  int exp_phase = 0;
  bit finished = 0;
  logic [15:0] gold [NW];
  logic [15:0] ram [NW];

  logic [7:0] exp_q [$];
  string      tag_q [$];
  event       sample_ev;

  always #(CLK_P / 2) clk = ~clk;

  prom_byteser_prog #(.WORDS(NW)) u_prom_byteser_prog (
    .clk(clk), .rst_n(rst_n), .prog_clk(prog_clk), .mode(mode),
    .vpp_ok(vpp_ok), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 257) ^ 16'hA55A;
  endfunction

  // memory model: synchronous, one cycle read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) ram[i] <= pat(i);
      mem_rdata <= '0;
    end else begin
      if (mem_wr) begin
        if (mem_be[1]) ram[mem_addr][15:8] <= mem_wdata[15:8];
        if (mem_be[0]) ram[mem_addr][7:0]  <= mem_wdata[7:0];
      end
      mem_rdata <= ram[mem_addr];
    end
  end

  always @(posedge clk) if (rst_n && mem_wr) wr_seen++;

  task automatic check_int(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (d_out !== e) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", t, d_out, e);
        end
      end
    end
  end

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode = m;
    if (vpp_ok && m == MD_CLR) begin
      exp_addr = 0;
      exp_phase = 0;
    end
    settle();
  endtask

  task automatic model_fall();
    if (vpp_ok && mode != MD_CLR) begin
      if (exp_phase == 2 && exp_addr < LASTB) exp_addr++;
      exp_phase = (exp_phase + 1) % 4;
    end
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      prog_clk = 1'b1;
      repeat (4) @(negedge clk);
      prog_clk = 1'b0;
      model_fall();
      repeat (4) @(negedge clk);
    end
  endtask

  function automatic logic [7:0] gold_byte(input int a);
    return a[0] ? gold[a / 2][7:0] : gold[a / 2][15:8];
  endfunction

  task automatic gold_write(input int a, input logic [7:0] v);
    if (a[0]) gold[a / 2][7:0] = v;
    else      gold[a / 2][15:8] = v;
  endtask

  // read at the current pointer, leave in inhibit
  task automatic read_check(input string tag);
    set_mode(MD_RD);
    check_int({tag, " oe in read"}, int'(d_oe), 1);
    exp_q.push_back(gold_byte(exp_addr));
    tag_q.push_back(tag);
    -> sample_ev;
    #1;
    set_mode(MD_INH);
    check_int("R7 oe drops after bit0 rise", int'(d_oe), 0);
  endtask

  task automatic write_byte(input logic [7:0] v);
    d_in = v;
    set_mode(MD_WR);
    set_mode(MD_INH);
    gold_write(exp_addr, v);
  endtask

  initial begin
    int w0;
    for (int i = 0; i < NW; i++) gold[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_int("R7 reset oe low", int'(d_oe), 0);
    check_int("R7 reset no write", int'(mem_wr), 0);

    // R3 R5: clear, read upper byte of word 0
    vpp_ok = 1'b1;
    settle();
    set_mode(MD_CLR);
    set_mode(MD_INH);
    read_check("R5 even byte is upper half");

    // R4: two pulses keep pointer, third steps it
    pulse(2);
    read_check("R4 no step before third pulse");
    pulse(1);
    read_check("R5 odd byte is lower half");
    pulse(3);
    read_check("R4 one step per group");
    pulse(1);
    read_check("R4 step on third fall of next group");

    // R6: write upper byte of word 1, lower half untouched
    w0 = wr_seen;
    d_in = 8'h3C;
    set_mode(MD_WR);
    d_in = 8'hC3;
    settle();
    set_mode(MD_INH);
    gold_write(exp_addr, 8'hC3);
    d_in = 8'h99;
    settle();
    check_int("R6 one strobe per commit", wr_seen - w0, 1);
    read_check("R6 last byte before bit0 rise written");
    pulse(4);
    read_check("R6 other lane untouched");

    // R8: rewrite the same address
    w0 = wr_seen;
    write_byte(8'h11);
    write_byte(8'h77);
    check_int("R8 two strobes", wr_seen - w0, 2);
    read_check("R8 last rewrite wins, pointer held");

    // R1: unlisted code has no effect
    w0 = wr_seen;
    set_mode(4'b1000);
    check_int("R1 unlisted code no drive", int'(d_oe), 0);
    set_mode(4'b1001);
    set_mode(MD_INH);
    check_int("R1 unlisted code no write", wr_seen - w0, 0);
    read_check("R1 pointer kept after unlisted code");

    // R2: no programming voltage
    w0 = wr_seen;
    vpp_ok = 1'b0;
    settle();
    d_in = 8'hEE;
    set_mode(MD_WR);
    set_mode(MD_INH);
    pulse(8);
    set_mode(MD_RD);
    check_int("R2 no drive without voltage", int'(d_oe), 0);
    set_mode(MD_CLR);
    set_mode(MD_INH);
    check_int("R2 no write without voltage", wr_seen - w0, 0);
    vpp_ok = 1'b1;
    settle();
    read_check("R2 pointer and data kept without voltage");

    // R3: clear mid-group resets phase
    pulse(2);
    set_mode(MD_CLR);
    set_mode(MD_INH);
    pulse(1);
    read_check("R3 clear resets phase");
    pulse(2);
    read_check("R3 fresh group steps on third");

    // R10: commit and step in the same cycle
    set_mode(MD_CLR);
    set_mode(MD_INH);
    pulse(2);
    d_in = 8'h5A;
    set_mode(MD_WR);
    prog_clk = 1'b1;
    settle();
    w0 = wr_seen;
    gold_write(exp_addr, 8'h5A);
    prog_clk = 1'b0;
    mode = MD_INH;
    model_fall();
    settle();
    check_int("R10 single strobe on collision", wr_seen - w0, 1);
    check_int("R10 pointer stepped", exp_addr, 1);
    read_check("R10 pointer moved past written byte");
    set_mode(MD_CLR);
    set_mode(MD_INH);
    read_check("R10 byte landed at old pointer");

    // R9: saturation
    pulse(4 * (LASTB + 3));
    check_int("R9 model saturates", exp_addr, LASTB);
    read_check("R9 last byte after saturation");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule